// File: doc/BRIEF.md
# AES-128 Single-Round-Per-Cycle Encryption Loop

This block encrypts one 128-bit block under a 128-bit key with AES-128, spending one clock cycle on each round. A one-cycle `start` pulse captures the plaintext and key. In that same cycle the initial key addition is formed and written into the block's only state register. The ten cipher rounds then follow, one per clock, and the whole encryption occupies 11 cycles including the start cycle.

The state register feeds the byte-substitution layer. Row rotation, column mixing, the loop multiplexer and the key addition form one combinational path back to that register, so every cycle carries a complete round. A key-expansion unit runs beside the datapath and presents the next round key each cycle. The ciphertext bus is driven directly from the key-addition output. When the final round completes, the register, the key unit and the round counter freeze, so the result stays on the bus until the next start.

Top module: `aes_loop_core`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `done` and `busy` are low.
- R2: When `start` is sampled high at a rising edge, `done` goes high in the tenth cycle after that edge. The start cycle is cycle 1 and `done` arrives in cycle 11.
- R3: In the cycle where `done` is high, `ciphertext` equals the AES-128 encryption of `plaintext` under `key` as sampled with `start`. Byte 0 of every 128-bit bus sits in bits 127:120, and the state is column-major.
- R4: `done` stays high for exactly one cycle. `busy` is high from the cycle after a start through the cycle with `done`, and it is low in the cycle after `done`.
- R5: Once an encryption has completed and `start` stays low, `ciphertext` keeps its value, and changes on `plaintext` or `key` have no effect on it.
- R6: A `start` during a running encryption abandons that run and restarts from the new inputs. No `done` is given for the abandoned run, and `done` is never high in a cycle where `start` is high.
- R7: A reset raised during an encryption aborts it, and no `done` follows until a new start.
- R8: The final round omits column mixing while rounds 1 to 9 include it. The standard test vectors in R3 only match when this holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that loads plaintext and key and begins a run |
| plaintext | input | 128 | Block to encrypt, sampled with start |
| key | input | 128 | Cipher key, sampled with start |
| ciphertext | output | 128 | Key-addition output, valid when done is high and held afterwards |
| busy | output | 1 | High while rounds 1 to 10 are in progress |
| done | output | 1 | One-cycle pulse marking the final round's result |

## Verification
The checker assumes that only `start` or reset changes the round sequence, and that `plaintext` and `key` matter only in a cycle where `start` is high. The latency counter and the hold property rest on that assumption. The bench drives `start` as single-cycle pulses on the falling edge, and it changes `plaintext` and `key` only while idle or together with a start. Restart and reset-abort cases are placed well inside a run, so the abandoned encryption can be seen to stay silent.

// File: rtl/aes_loop_pkg.sv
package aes_loop_pkg;

    localparam int BLK_W      = 128;
    localparam int BYTE_W     = 8;
    localparam int N_BYTES    = BLK_W / BYTE_W;
    localparam int N_ROWS     = 4;
    localparam int N_COLS     = N_BYTES / N_ROWS;
    localparam int RCON_SPAN  = 14;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [BLK_W-1:0]  block_t;

    typedef struct packed {
        logic load;
        logic step;
        logic last;
    } rnd_ctl_t;

    function automatic byte_t xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // a^254: multiplicative inverse, zero maps to zero
    function automatic byte_t gf_inv(input byte_t a);
        byte_t pw;
        byte_t res;
        pw  = a;
        res = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            pw  = gf_mul(pw, pw);
            res = gf_mul(res, pw);
        end
        return res;
    endfunction

    function automatic byte_t sbox_fwd(input byte_t a);
        byte_t v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    function automatic byte_t rcon_at(input int r);
        byte_t v;
        v = 8'h01;
        for (int k = 2; k <= RCON_SPAN; k++) begin
            if (k <= r) v = xtime(v);
        end
        return v;
    endfunction

    function automatic logic [31:0] sub_word(input logic [31:0] w);
        return {sbox_fwd(w[31:24]), sbox_fwd(w[23:16]),
                sbox_fwd(w[15:8]),  sbox_fwd(w[7:0])};
    endfunction

    function automatic block_t key_next(input block_t k, input byte_t rc);
        logic [31:0] t, w0, w1, w2, w3;
        t  = sub_word({k[23:0], k[31:24]}) ^ {rc, 24'h0};
        w0 = k[127:96] ^ t;
        w1 = k[95:64]  ^ w0;
        w2 = k[63:32]  ^ w1;
        w3 = k[31:0]   ^ w2;
        return {w0, w1, w2, w3};
    endfunction

endpackage

// File: rtl/aes_sub_layer.sv
module aes_sub_layer
    import aes_loop_pkg::*;
(
    input  block_t blk_i,
    output block_t blk_o
);
    for (genvar g = 0; g < N_BYTES; g++) begin : g_sbox
        localparam int HI = BLK_W - 1 - BYTE_W * g;
        assign blk_o[HI -: BYTE_W] = sbox_fwd(blk_i[HI -: BYTE_W]);
    end
endmodule

// File: rtl/aes_mix_layer.sv
module aes_mix_layer
    import aes_loop_pkg::*;
(
    input  block_t blk_i,
    input  logic   skip_mix,
    output block_t blk_o
);
    block_t shifted;
    block_t mixed;

    // row r of column c takes the byte from column (c + r) mod 4
    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        for (genvar r = 0; r < N_ROWS; r++) begin : g_row
            localparam int DST = BLK_W - 1 - BYTE_W * (r + N_ROWS * c);
            localparam int SRC = BLK_W - 1 - BYTE_W * (r + N_ROWS * ((c + r) % N_COLS));
            assign shifted[DST -: BYTE_W] = blk_i[SRC -: BYTE_W];
        end

        localparam int TOP = BLK_W - 1 - BYTE_W * N_ROWS * c;
        byte_t a0, a1, a2, a3;
        assign a0 = shifted[TOP      -: BYTE_W];
        assign a1 = shifted[TOP - 8  -: BYTE_W];
        assign a2 = shifted[TOP - 16 -: BYTE_W];
        assign a3 = shifted[TOP - 24 -: BYTE_W];
        assign mixed[TOP      -: BYTE_W] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
        assign mixed[TOP - 8  -: BYTE_W] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
        assign mixed[TOP - 16 -: BYTE_W] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
        assign mixed[TOP - 24 -: BYTE_W] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end

    assign blk_o = skip_mix ? shifted : mixed;
endmodule

// File: rtl/aes_key_unit.sv
module aes_key_unit
    import aes_loop_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   step,
    input  byte_t  rc_next,
    input  block_t key_i,
    output block_t rk_o
);
    block_t rk_q;

    assign rk_o = load ? key_i : rk_q;

    always_ff @(posedge clk) begin
        if (rst)              rk_q <= '0;
        else if (load | step) rk_q <= key_next(rk_o, rc_next);
    end
endmodule

// File: rtl/aes_round_ctrl.sv
module aes_round_ctrl
    import aes_loop_pkg::*;
#(
    parameter int ROUNDS = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output rnd_ctl_t ctl,
    output byte_t    rc_next,
    output logic     busy,
    output logic     done
);
    localparam int CNT_W = $clog2(ROUNDS + 1);
    localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] rnd_q;
    logic             busy_q;
    logic             last;

    assign last     = (rnd_q == LAST_RND);
    assign ctl.load = start;
    assign ctl.step = busy_q & ~last & ~start;
    assign ctl.last = last;
    assign rc_next  = start ? rcon_at(1) : rcon_at(int'(rnd_q) + 1);
    assign busy     = busy_q;
    assign done     = busy_q & last & ~start;

    always_ff @(posedge clk) begin
        if (rst) begin
            rnd_q  <= LAST_RND;
            busy_q <= 1'b0;
        end else if (start) begin
            rnd_q  <= ONE;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (last) busy_q <= 1'b0;
            else      rnd_q  <= rnd_q + ONE;
        end
    end
endmodule

// File: rtl/aes_loop_core.sv
module aes_loop_core
    import aes_loop_pkg::*;
#(
    parameter int ROUNDS = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [127:0] plaintext,
    input  logic [127:0] key,
    output logic [127:0] ciphertext,
    output logic         busy,
    output logic         done
);
    rnd_ctl_t ctl;
    byte_t    rc_next;
    block_t   rk;
    block_t   st_q;
    block_t   sub_out;
    block_t   mix_out;
    block_t   loop_in;
    block_t   ark;

    aes_round_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .ctl(ctl), .rc_next(rc_next), .busy(busy), .done(done)
    );

    aes_key_unit u_key (
        .clk(clk), .rst(rst), .load(ctl.load), .step(ctl.step),
        .rc_next(rc_next), .key_i(key), .rk_o(rk)
    );

    aes_sub_layer u_sub (.blk_i(st_q), .blk_o(sub_out));

    aes_mix_layer u_mix (.blk_i(sub_out), .skip_mix(ctl.last), .blk_o(mix_out));

    assign loop_in    = start ? plaintext : mix_out;
    assign ark        = loop_in ^ rk;
    assign ciphertext = ark;

    always_ff @(posedge clk) begin
        if (rst)                      st_q <= '0;
        else if (ctl.load | ctl.step) st_q <= ark;
    end
endmodule

// File: rtl/aes_loop_chk.sv
module aes_loop_chk #(
    parameter int ROUNDS = 10
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [127:0] ct
);
    logic [4:0] since_start;

    always_ff @(posedge clk) begin
        if (rst)                                          since_start <= '0;
        else if (start)                                   since_start <= 5'd1;
        else if (since_start != 5'd0 && since_start != 5'h1f) since_start <= since_start + 5'd1;
    end

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> since_start == 5'(ROUNDS));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R4
    done_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R5
    ct_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> (start || $stable(ct)));

    // R6
    no_done_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !done);
endmodule

bind aes_loop_core aes_loop_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .ct(ciphertext)
);

// File: tb/tb_aes_loop_core.sv
`timescale 1ns/1ps
module tb_aes_loop_core;

    localparam int NV = 3;
    localparam logic [127:0] V_PT [NV] = '{
        128'h00112233445566778899aabbccddeeff,
        128'h3243f6a8885a308d313198a2e0370734,
        128'h00000000000000000000000000000000
    };
    localparam logic [127:0] V_KEY [NV] = '{
        128'h000102030405060708090a0b0c0d0e0f,
        128'h2b7e151628aed2a6abf7158809cf4f3c,
        128'h00000000000000000000000000000000
    };
    localparam logic [127:0] V_CT [NV] = '{
        128'h69c4e0d86a7b0430d8cdb78070b4c55a,
        128'h3925841d02dc09fbdc118597196a0b32,
        128'h66e94bd4ef8a2c3b884cfa59ca342b2e
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [127:0] pt, key;
    logic [127:0] ct;
    logic         busy, done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    aes_loop_core dut (
        .clk(clk), .rst(rst), .start(start), .plaintext(pt), .key(key),
        .ciphertext(ct), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // sits at a falling edge on entry; leaves at the falling edge of the done cycle
    task automatic run_enc(input logic [127:0] p, input logic [127:0] k,
                           output int lat, output logic [127:0] res);
        start = 1'b1; pt = p; key = k;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        check(busy == 1'b1, "R4 busy after start", 128'(busy), 128'd1);
        while (!done && lat < 30) begin
            @(negedge clk);
            lat++;
        end
        res = ct;
    endtask

    initial begin
        int lat;
        logic [127:0] res;
        bit early;

        rst = 1'b1; start = 1'b0; pt = '0; key = '0;
        repeat (3) @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R1 in reset", {busy, done}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R1 after reset", {busy, done}, 128'd0);

        for (int i = 0; i < NV; i++) begin
            run_enc(V_PT[i], V_KEY[i], lat, res);
            check(lat == 10, "R2 latency", 128'(lat), 128'd10);
            check(res == V_CT[i], "R3 R8 ciphertext", res, V_CT[i]);
            @(negedge clk);
            check(done == 1'b0, "R4 done single pulse", 128'(done), 128'd0);
            check(busy == 1'b0, "R4 busy low after done", 128'(busy), 128'd0);
            pt  = ~V_PT[i];
            key = V_KEY[i] ^ 128'h5a5a;
            repeat (4) @(negedge clk);
            check(ct == V_CT[i], "R5 ciphertext held", ct, V_CT[i]);
            check(done == 1'b0, "R5 no done while idle", 128'(done), 128'd0);
        end

        // R6 restart in the middle of a run
        start = 1'b1; pt = V_PT[2]; key = V_KEY[2];
        @(negedge clk);
        start = 1'b0;
        early = 0;
        repeat (4) begin
            if (done) early = 1;
            @(negedge clk);
        end
        check(early == 0, "R6 no done before restart", 128'(early), 128'd0);
        run_enc(V_PT[1], V_KEY[1], lat, res);
        check(lat == 10, "R6 restart latency", 128'(lat), 128'd10);
        check(res == V_CT[1], "R6 restart result", res, V_CT[1]);
        @(negedge clk);

        // R7 reset abort
        start = 1'b1; pt = V_PT[0]; key = V_KEY[0];
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        early = 0;
        repeat (15) begin
            @(negedge clk);
            if (done || busy) early = 1;
        end
        check(early == 0, "R7 aborted run silent", 128'(early), 128'd0);

        run_enc(V_PT[0], V_KEY[0], lat, res);
        check(lat == 10, "R7 latency after abort", 128'(lat), 128'd10);
        check(res == V_CT[0], "R3 result after abort", res, V_CT[0]);

        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 128'd0, 128'd1);
        finish_run();
    end

endmodule